// File: doc/BRIEF.md
# System Board Keyboard and Configuration Port Unit

This block is the fixed-direction parallel port group of an early personal-computer system board. It sits at four I/O addresses. Two read-only ports return board-level inputs, one output latch steers those inputs, and one write-only mode location is accepted for software compatibility. The read-only port at offset 0 returns either the configuration switch byte or the last keyboard scan code. The read-only port at offset 2 returns the expansion-memory switch nibble and four live or latched status bits. Bits of the output latch at offset 1 choose the sources and enable the error reporting.

A serial keyboard receiver synchronises the keyboard clock and data lines, shifts one data bit on each falling clock edge, and raises a keyboard interrupt once eight bits are held. The code and the interrupt stay frozen until software sets the keyboard-select bit of the output latch. While that bit is set, the receiver is held empty. Software then clears the bit to arm the receiver for the next code.

Top module: `sysport_unit`

## Requirements
- R1: After reset the output latch reads 00h, `irq_kbd` is low and offset 0 reads 00h (empty scan code).
- R2: A write to offset 1 loads the output latch, and a read of offset 1 returns the latched byte.
- R3: A read of offset 3 returns the fixed direction word 99h. A write to offset 3 changes no port.
- R4: When latch bit 7 is 1, offset 0 returns `cfg_sw` unchanged. Its fields are bit 0 floppy present, bit 1 coprocessor present, bits 3:2 memory size, bits 5:4 display type, and bits 7:6 drive count minus one.
- R5: Each falling edge of `kb_clk` shifts `kb_data` into the receiver, first bit ending in bit 0. After the eighth edge `irq_kbd` goes high, and offset 0 with latch bit 7 at 0 returns the code.
- R6: Once a code is complete, further keyboard edges change neither the code nor `irq_kbd`. Setting latch bit 7 empties the receiver and drops `irq_kbd`.
- R7: Offset 2 bits 3:0 return `mem_sw` when latch bit 2 is 0, and 0000b when it is 1.
- R8: Offset 2 bit 5 returns `tmr2_out` live, and bit 4 returns `cass_in` live.
- R9: Offset 2 bit 7 is a sticky parity-error flag and bit 6 a sticky channel-check flag. Each is set by its input while its enable (latch bit 4 for parity, bit 5 for channel check) is 1. Each clears and stays clear while its enable is 0.
- R10: Writes to offsets 0 and 2 are ignored: the latch and both input ports read as before.
- R11: Fewer than eight keyboard edges leave `irq_kbd` low. Setting latch bit 7 discards the partial bits, so the next code is assembled from a fresh count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| io_sel | input | 1 | Port group selected for this bus cycle |
| io_wr | input | 1 | Write strobe, one clock |
| io_addr | input | 2 | Port offset within the group |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data of the addressed port |
| cfg_sw | input | 8 | Configuration switch byte |
| mem_sw | input | 4 | Expansion-memory switch nibble |
| kb_clk | input | 1 | Keyboard clock, asynchronous, idle high |
| kb_data | input | 1 | Keyboard serial data, asynchronous |
| par_err | input | 1 | RAM parity error event |
| chan_chk | input | 1 | Expansion channel check event |
| tmr2_out | input | 1 | Timer 2 output level |
| cass_in | input | 1 | Cassette data input level |
| irq_kbd | output | 1 | Keyboard interrupt request |
| pb_q | output | 8 | Output latch contents |

## Verification
A miscounted or mis-shifted receiver shows at offset 0 as a rotated or shifted code, or as an interrupt one edge early or late. Either shows within about five clocks of the eighth keyboard edge. A clear that does not reset the bit count corrupts the next whole code rather than the current one, so the bench sends a partial code, clears, and then checks a complete code. A sticky flag that does not clear stays visible at offset 2 one clock after its enable drops, and a latch that reacts to the wrong offset shows up in the next read of offset 1.

// File: rtl/sysport_pkg.sv
package sysport_pkg;
  typedef enum logic [1:0] {
    SEL_PA   = 2'd0,
    SEL_PB   = 2'd1,
    SEL_PC   = 2'd2,
    SEL_MODE = 2'd3
  } port_sel_e;

  // fixed direction word: A in, B out, C in (both halves)
  localparam logic [7:0] MODE_FIXED = 8'h99;

  // output latch bit positions
  localparam int unsigned PB_MEMSEL = 2;
  localparam int unsigned PB_PAR_EN = 4;
  localparam int unsigned PB_CHK_EN = 5;
  localparam int unsigned PB_KSEL   = 7;

  // sticky flag indices
  localparam int unsigned FLG_PAR = 0;
  localparam int unsigned FLG_CHK = 1;
  localparam int unsigned FLG_N   = 2;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;
      always_comb chain_d = {chain_q[STAGES-2:0], d[gi]};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL[gi]}};
        else        chain_q <= chain_d;
      end
      assign q[gi] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sp_kbd_shift.sv
module sp_kbd_shift #(
  parameter int unsigned BITS = 8,
  localparam int unsigned CW = $clog2(BITS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            kclk_s,
  input  logic            kdat_s,
  input  logic            clr,
  output logic [BITS-1:0] code,
  output logic            full
);
  logic            prev_q, prev_d;
  logic [BITS-1:0] sr_q, sr_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            full_q, full_d;
  logic            fall;

  always_comb begin
    fall   = prev_q & ~kclk_s;
    prev_d = kclk_s;
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    full_d = full_q;
    if (clr) begin
      sr_d   = '0;
      cnt_d  = '0;
      full_d = 1'b0;
    end else if (fall && !full_q) begin
      sr_d  = {kdat_s, sr_q[BITS-1:1]};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(BITS - 1)) full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      sr_q   <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  assign code = sr_q;
  assign full = full_q;

  a_r5_irq_after_eight: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(cnt_q == CW'(BITS - 1)));
  a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !clr) |=> full_q);
  a_r6_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !clr) |=> $stable(sr_q));
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!full_q && cnt_q == '0 && sr_q == '0));
endmodule

// File: rtl/sp_chk_latch.sv
module sp_chk_latch #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] en,
  input  logic [N-1:0] evt,
  output logic [N-1:0] flag
);
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_flag
      logic f_q, f_d;
      always_comb f_d = en[gi] ? (f_q | evt[gi]) : 1'b0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= 1'b0;
        else        f_q <= f_d;
      end
      assign flag[gi] = f_q;

      a_r9_clear_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en[gi] |=> !f_q);
      a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (en[gi] && f_q) |=> f_q);
    end
  endgenerate
endmodule

// File: rtl/sysport_unit.sv
module sysport_unit
  import sysport_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned MSW_W      = DW - 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_sel,
  input  logic             io_wr,
  input  logic [1:0]       io_addr,
  input  logic [DW-1:0]    io_wdata,
  output logic [DW-1:0]    io_rdata,
  input  logic [DW-1:0]    cfg_sw,
  input  logic [MSW_W-1:0] mem_sw,
  input  logic             kb_clk,
  input  logic             kb_data,
  input  logic             par_err,
  input  logic             chan_chk,
  input  logic             tmr2_out,
  input  logic             cass_in,
  output logic             irq_kbd,
  output logic [DW-1:0]    pb_q
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ni = rst_q[1];

  // keyboard line synchroniser (clock idles high)
  logic [1:0] kb_s;
  sp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_kb_sync (
    .clk  (clk),
    .rst_n(rst_ni),
    .d    ({kb_data, kb_clk}),
    .q    (kb_s)
  );

  // output latch
  logic [DW-1:0] pb_r, pb_d;
  logic          pb_we;
  always_comb begin
    pb_we = io_sel && io_wr && (port_sel_e'(io_addr) == SEL_PB);
    pb_d  = pb_we ? io_wdata : pb_r;
  end
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pb_r <= '0;
    else         pb_r <= pb_d;
  end
  assign pb_q = pb_r;

  // keyboard receiver
  logic [DW-1:0] kcode;
  logic          kfull;
  sp_kbd_shift #(.BITS(DW)) u_kbd (
    .clk   (clk),
    .rst_n (rst_ni),
    .kclk_s(kb_s[0]),
    .kdat_s(kb_s[1]),
    .clr   (pb_r[PB_KSEL]),
    .code  (kcode),
    .full  (kfull)
  );
  assign irq_kbd = kfull;

  // sticky error flags
  logic [FLG_N-1:0] flg;
  logic [FLG_N-1:0] flg_en, flg_evt;
  always_comb begin
    flg_en           = '0;
    flg_evt          = '0;
    flg_en[FLG_PAR]  = pb_r[PB_PAR_EN];
    flg_en[FLG_CHK]  = pb_r[PB_CHK_EN];
    flg_evt[FLG_PAR] = par_err;
    flg_evt[FLG_CHK] = chan_chk;
  end
  sp_chk_latch #(.N(FLG_N)) u_chk (
    .clk  (clk),
    .rst_n(rst_ni),
    .en   (flg_en),
    .evt  (flg_evt),
    .flag (flg)
  );

  // read mux
  logic [DW-1:0]    pa_val, pc_val;
  logic [MSW_W-1:0] pc_low;
  always_comb begin
    pa_val = pb_r[PB_KSEL] ? cfg_sw : kcode;
    pc_low = pb_r[PB_MEMSEL] ? '0 : mem_sw;
    pc_val = {flg[FLG_PAR], flg[FLG_CHK], tmr2_out, cass_in, pc_low};
    unique case (port_sel_e'(io_addr))
      SEL_PA:   io_rdata = pa_val;
      SEL_PB:   io_rdata = pb_r;
      SEL_PC:   io_rdata = pc_val;
      default:  io_rdata = MODE_FIXED;
    endcase
  end

  a_r2_latch_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    !pb_we |=> $stable(pb_r));
  a_r2_latch_loads: assert property (@(posedge clk) disable iff (!rst_ni)
    pb_we |=> (pb_r == $past(io_wdata)));
  a_r6_irq_drops_on_select: assert property (@(posedge clk) disable iff (!rst_ni)
    pb_r[PB_KSEL] |=> !irq_kbd);
endmodule

// File: tb/sysport_unit_tb.sv
module sysport_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_sel = 1'b0, io_wr = 1'b0;
  logic [1:0] io_addr = 2'd0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic [7:0] cfg_sw = 8'h00;
  logic [3:0] mem_sw = 4'h0;
  logic       kb_clk = 1'b1, kb_data = 1'b0;
  logic       par_err = 1'b0, chan_chk = 1'b0, tmr2_out = 1'b0, cass_in = 1'b0;
  logic       irq_kbd;
  logic [7:0] pb_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sysport_unit dut_i (
    .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_sw(cfg_sw), .mem_sw(mem_sw),
    .kb_clk(kb_clk), .kb_data(kb_data), .par_err(par_err), .chan_chk(chan_chk),
    .tmr2_out(tmr2_out), .cass_in(cass_in), .irq_kbd(irq_kbd), .pb_q(pb_q)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    io_sel = 1'b1; io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_sel = 1'b0; io_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a;
    #1 d = io_rdata;
  endtask

  task automatic kbit(input logic b);
    @(negedge clk); kb_data = b;
    repeat (3) @(negedge clk);
    kb_clk = 1'b0;
    repeat (6) @(negedge clk);
    kb_clk = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic kbyte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) kbit(v[i]);
  endtask

  task automatic kclear();
    wr(2'd1, 8'h80);
    wr(2'd1, 8'h00);
  endtask

  function automatic logic [7:0] exp_pc(input logic [7:0] pb, input logic [3:0] ms,
                                        input logic pf, input logic cf,
                                        input logic t2, input logic cs);
    return {pf, cf, t2, cs, pb[2] ? 4'h0 : ms};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, v, pbv;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd1, r); chk("R1 latch", r, 8'h00);
    chk("R1 irq", {7'd0, irq_kbd}, 8'h00);
    rd(2'd0, r); chk("R1 code", r, 8'h00);

    // R2 latch readback
    wr(2'd1, 8'h5A); rd(2'd1, r); chk("R2 readback", r, 8'h5A);
    chk("R2 pin", pb_q, 8'h5A);

    // R3 mode location
    rd(2'd3, r); chk("R3 mode read", r, 8'h99);
    wr(2'd3, 8'h80); rd(2'd1, r); chk("R3 no effect latch", r, 8'h5A);
    rd(2'd3, r); chk("R3 mode after write", r, 8'h99);

    // R10 writes to input ports ignored
    cfg_sw = 8'h7D; mem_sw = 4'h9;
    wr(2'd0, 8'hFF); wr(2'd2, 8'hFF);
    rd(2'd1, r); chk("R10 latch", r, 8'h5A);
    wr(2'd1, 8'h80);
    rd(2'd0, r); chk("R10/R4 switches", r, 8'h7D);
    rd(2'd2, r); chk("R10/R7 port C", r, exp_pc(8'h80, 4'h9, 0, 0, 0, 0));

    // R4 switch byte
    cfg_sw = 8'hA2; rd(2'd0, r); chk("R4 switches", r, 8'hA2);
    wr(2'd1, 8'h00);

    // R5 receive
    kbyte(8'h1C);
    chk("R5 irq", {7'd0, irq_kbd}, 8'h01);
    rd(2'd0, r); chk("R5 code", r, 8'h1C);

    // R6 frozen then cleared
    kbyte(8'hFF);
    rd(2'd0, r); chk("R6 frozen code", r, 8'h1C);
    chk("R6 irq held", {7'd0, irq_kbd}, 8'h01);
    wr(2'd1, 8'h80);
    @(negedge clk);
    chk("R6 irq drops", {7'd0, irq_kbd}, 8'h00);
    wr(2'd1, 8'h00);
    rd(2'd0, r); chk("R6 emptied", r, 8'h00);

    // R11 partial then clear
    for (int i = 0; i < 5; i++) kbit(1'b1);
    chk("R11 partial irq", {7'd0, irq_kbd}, 8'h00);
    kclear();
    kbyte(8'h42);
    rd(2'd0, r); chk("R11 fresh code", r, 8'h42);
    chk("R11 irq", {7'd0, irq_kbd}, 8'h01);
    kclear();

    // R7 / R8 low nibble select and live bits
    mem_sw = 4'hB; tmr2_out = 1'b1; cass_in = 1'b0;
    rd(2'd2, r); chk("R7/R8 sel0", r, exp_pc(8'h00, 4'hB, 0, 0, 1, 0));
    wr(2'd1, 8'h04); tmr2_out = 1'b0; cass_in = 1'b1;
    rd(2'd2, r); chk("R7/R8 sel1", r, exp_pc(8'h04, 4'hB, 0, 0, 0, 1));

    // R9 sticky flags
    wr(2'd1, 8'h30); cass_in = 1'b0;
    @(negedge clk); par_err = 1'b1; @(negedge clk); par_err = 1'b0;
    repeat (2) @(negedge clk);
    rd(2'd2, r); chk("R9 parity sticky", r, exp_pc(8'h30, 4'hB, 1, 0, 0, 0));
    @(negedge clk); chan_chk = 1'b1; @(negedge clk); chan_chk = 1'b0;
    rd(2'd2, r); chk("R9 both sticky", r, exp_pc(8'h30, 4'hB, 1, 1, 0, 0));
    wr(2'd1, 8'h20);
    rd(2'd2, r); chk("R9 parity cleared", r, exp_pc(8'h20, 4'hB, 0, 1, 0, 0));
    @(negedge clk); par_err = 1'b1; @(negedge clk); par_err = 1'b0;
    rd(2'd2, r); chk("R9 disabled ignores", r, exp_pc(8'h20, 4'hB, 0, 1, 0, 0));
    wr(2'd1, 8'h00);
    rd(2'd2, r); chk("R9 chk cleared", r, exp_pc(8'h00, 4'hB, 0, 0, 0, 0));

    // random mix
    for (int it = 0; it < 16; it++) begin
      v = 8'($urandom);
      kbyte(v);
      rd(2'd0, r); chk("R5 random code", r, v);
      chk("R5 random irq", {7'd0, irq_kbd}, 8'h01);
      pbv = 8'($urandom) & 8'hCF;
      pbv[7] = 1'b1;
      cfg_sw = 8'($urandom); mem_sw = 4'($urandom);
      tmr2_out = 1'($urandom); cass_in = 1'($urandom);
      wr(2'd1, pbv);
      rd(2'd1, r); chk("R2 random latch", r, pbv);
      rd(2'd0, r); chk("R4 random switches", r, cfg_sw);
      rd(2'd2, r); chk("R7/R8 random port C", r, exp_pc(pbv, mem_sw, 0, 0, tmr2_out, cass_in));
      wr(2'd1, 8'h00);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule